// File: doc/BRIEF.md
# Partial-Word Store Aligner

This block turns a byte-addressed "store leading bytes" or "store trailing bytes" request into a single masked write on a big-endian memory port. It takes a byte address, a register value and a mode select. From the low address bits it picks the byte lanes to write and clears the rest. It then presents one word-aligned address, a byte-enable mask and lane-aligned write data. Because every store leaves as one masked write, the three-byte cases reach memory as one indivisible access.

The two modes use complementary lanes. Begin mode writes from the addressed byte to the end of the word, taking the value's low-order bytes. End mode writes from the start of the word up to, but not including, the addressed byte, taking the value's high-order bytes. An end-mode store to an aligned address writes no byte. It still leaves as a write access with a probe flag, so that a later stage can apply permission checks and dirty marking. A one-deep output register with a valid/ready handshake sits between the request and memory.

Top module: `partial_store_aligner`

## Requirements
- R1: After reset, memValid is low and reqReady is high.
- R2: memAddr is the accepted reqAddr with its two low bits cleared.
- R3: Memory is big-endian. Lane k (byte address offset k) is memData bits [31-8k -: 8] and is enabled by memByteEn[3-k]. In begin mode (reqEndMode=0) with offset o, lanes o..3 are enabled: offset 0 gives 4'b1111, 1 gives 4'b0111, 2 gives 4'b0011, 3 gives 4'b0001.
- R4: In end mode (reqEndMode=1) with offset o other than 0, lanes 0..o-1 are enabled: offset 1 gives 4'b1000, 2 gives 4'b1100, 3 gives 4'b1110.
- R5: An end-mode store with offset 0 drives memByteEn 4'b0000 and memProbeOnly high, and still raises memValid. Every other store drives memProbeOnly low.
- R6: Each enabled lane carries the byte of reqData in that same bit position, so a begin store writes the value's low bytes and an end store writes its high bytes. Every disabled lane is driven to zero.
- R7: A request is taken only in a cycle where reqValid and reqReady are both high. memValid is high in the cycle after it is taken.
- R8: While memValid is high and memReady is low, reqReady is low and every mem* output holds its value.
- R9: If a memory handshake completes and no new request is taken in that cycle, memValid falls. If a new request is taken in that cycle, the next store follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request present |
| reqReady | output | 1 | Aligner can take a request |
| reqAddr | input | ADDR_W | Byte address of the store |
| reqData | input | DATA_W | Register value to store |
| reqEndMode | input | 1 | 0 = begin mode, 1 = end mode |
| memValid | output | 1 | Masked write presented to memory |
| memReady | input | 1 | Memory takes the write |
| memAddr | output | ADDR_W | Word-aligned write address |
| memByteEn | output | DATA_W/8 | Byte enables, bit 3 = lowest-address lane |
| memData | output | DATA_W | Lane-aligned write data |
| memProbeOnly | output | 1 | Zero-byte write access (probe) |

## Verification
The hardest case to reach from the ports is a stall that overlaps a waiting request. The stall holds one store in the output register while memory is not ready and a second request is already on the input. The bench builds this case on purpose. It issues a store with memReady low, then raises a different request and keeps it there for several cycles. It then releases memReady. The bench checks that the held store never changes, that the waiting request is not taken early, and that the waiting request appears right after the release with no idle cycle. The zero-byte probe case is also driven between ordinary stores, so that it cannot inherit a stale mask.

// File: rtl/psa_pkg.sv
package psa_pkg;
  // Strobes passed from the handshake control to the datapath
  typedef struct packed {
    logic load;   // capture a new request into the output register
    logic drop;   // write retired with no replacement
  } psaStrobe_t;
endpackage

// File: rtl/psa_ctrl.sv
module psa_ctrl
  import psa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memReady,
  output logic       reqReady,
  output logic       memValid,
  output psaStrobe_t strobe
);
  logic validQ;

  always_comb begin
    reqReady     = !validQ || memReady;
    strobe.load  = reqValid && reqReady;
    strobe.drop  = validQ && memReady && !strobe.load;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (strobe.drop) validQ <= 1'b0;
  end

  assign memValid = validQ;
endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  psaStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                reqEndMode,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memData,
  output logic                memProbeOnly
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0]  offset;
  logic [LANES-1:0]  nextEn;
  logic [DATA_W-1:0] nextData;
  logic              nextProbe;

  assign offset    = reqAddr[OFF_W-1:0];
  assign nextProbe = reqEndMode && (offset == '0);

  // Lane k is the k-th byte from the lowest address; it lives in the
  // most significant byte position first (big-endian).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic laneOn;
    assign laneOn = reqEndMode ? (OFF_W'(k) < offset) : (OFF_W'(k) >= offset);
    assign nextEn[LANES-1-k] = laneOn;
    assign nextData[(LANES-1-k)*8 +: 8] = laneOn ? reqData[(LANES-1-k)*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr      <= '0;
      memByteEn    <= '0;
      memData      <= '0;
      memProbeOnly <= 1'b0;
    end else if (strobe.load) begin
      memAddr      <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      memByteEn    <= nextEn;
      memData      <= nextData;
      memProbeOnly <= nextProbe;
    end
  end
endmodule

// File: rtl/partial_store_aligner.sv
module partial_store_aligner
  import psa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                reqEndMode,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memData,
  output logic                memProbeOnly
);
  psaStrobe_t strobe;

  psa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memReady (memReady),
    .reqReady (reqReady),
    .memValid (memValid),
    .strobe   (strobe)
  );

  psa_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .reqEndMode   (reqEndMode),
    .memAddr      (memAddr),
    .memByteEn    (memByteEn),
    .memData      (memData),
    .memProbeOnly (memProbeOnly)
  );
endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                memValid,
  input logic                memReady,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic [DATA_W-1:0]   memData,
  input logic                memProbeOnly
);
  localparam int LANES = DATA_W / 8;
  logic [DATA_W-1:0] laneMask;

  always_comb begin
    for (int j = 0; j < LANES; j++) laneMask[j*8 +: 8] = {8{memByteEn[j]}};
  end

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memAddr[1:0] == 2'b00);

  assert_mask_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memProbeOnly) |-> memByteEn != '0);

  assert_probe_no_bytes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memProbeOnly) |-> memByteEn == '0);

  assert_idle_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memData & ~laneMask) == '0);

  assert_accept_raises_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memValid);

  assert_stall_blocks_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |-> !reqReady);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memByteEn)
                                 && $stable(memData) && $stable(memProbeOnly)));

  assert_retire_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !reqValid) |=> !memValid);
endmodule

bind partial_store_aligner psa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_partial_store_aligner.sv
module tb_partial_store_aligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqEndMode = 1'b0;
  logic        memValid;
  logic        memReady = 1'b1;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memData;
  logic        memProbeOnly;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  partial_store_aligner dut (.*);

  // {endMode, addr, data, expMask, expData, expProbe}
  localparam logic [101:0] VEC [8] = '{
    {1'b0, 32'h0000_1000, 32'hA1B2C3D4, 4'b1111, 32'hA1B2C3D4, 1'b0},
    {1'b0, 32'h0000_1001, 32'hA1B2C3D4, 4'b0111, 32'h00B2C3D4, 1'b0},
    {1'b0, 32'h0000_2002, 32'hA1B2C3D4, 4'b0011, 32'h0000C3D4, 1'b0},
    {1'b0, 32'h0000_3003, 32'hA1B2C3D4, 4'b0001, 32'h000000D4, 1'b0},
    {1'b1, 32'h0000_4000, 32'h5E6F7081, 4'b0000, 32'h00000000, 1'b1},
    {1'b1, 32'h0000_4001, 32'h5E6F7081, 4'b1000, 32'h5E000000, 1'b0},
    {1'b1, 32'h0000_5002, 32'h5E6F7081, 4'b1100, 32'h5E6F0000, 1'b0},
    {1'b1, 32'h0000_5FFF, 32'h5E6F7081, 4'b1110, 32'h5E6F7000, 1'b0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkOut(string req, logic [31:0] a, logic [3:0] m, logic [31:0] d, logic p);
    check({req, " valid"}, 64'(memValid), 64'(1));
    check({req, " addr"},  64'(memAddr), 64'(a));
    check({req, " mask"},  64'(memByteEn), 64'(m));
    check({req, " data"},  64'(memData), 64'(d));
    check({req, " probe"}, 64'(memProbeOnly), 64'(p));
  endtask

  task automatic drive(logic e, logic [31:0] a, logic [31:0] d);
    reqValid = 1'b1; reqEndMode = e; reqAddr = a; reqData = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 memValid", 64'(memValid), 64'(0));
    check("R1 reqReady", 64'(reqReady), 64'(1));
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      drive(VEC[i][101], VEC[i][100:69], VEC[i][68:37]);
      @(negedge clk);
      reqValid = 1'b0;
      checkOut(VEC[i][101] ? "R4/R5/R6/R2" : "R3/R6/R2",
               VEC[i][100:69] & 32'hFFFF_FFFC, VEC[i][36:33], VEC[i][32:1], VEC[i][0]);
      @(negedge clk);
      // R9: retired with no new request
      check("R9 drop", 64'(memValid), 64'(0));
    end

    // R7: valid without ready is not taken
    memReady = 1'b0;
    drive(1'b0, 32'h0000_6002, 32'h01234567);
    @(negedge clk);
    checkOut("R7 first", 32'h0000_6000, 4'b0011, 32'h00004567, 1'b0);
    drive(1'b1, 32'h0000_7000, 32'h89ABCDEF);   // probe store waits behind a stall
    repeat (3) begin
      @(negedge clk);
      check("R8 reqReady", 64'(reqReady), 64'(0));
      checkOut("R8 hold", 32'h0000_6000, 4'b0011, 32'h00004567, 1'b0);
    end
    memReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R9: waiting request follows without a gap; R5 probe after a masked store
    checkOut("R9 back-to-back R5", 32'h0000_7000, 4'b0000, 32'h00000000, 1'b1);
    @(negedge clk);
    check("R9 drop after probe", 64'(memValid), 64'(0));

    // R9: continuous requests with memory always ready
    drive(1'b1, 32'h0000_8003, 32'hCAFEF00D);
    @(negedge clk);
    checkOut("R4 stream a", 32'h0000_8000, 4'b1110, 32'hCAFEF000, 1'b0);
    drive(1'b0, 32'h0000_8001, 32'h0BADBEEF);
    @(negedge clk);
    reqValid = 1'b0;
    checkOut("R9 stream b R3", 32'h0000_8000, 4'b0111, 32'h00ADBEEF, 1'b0);

    // R1: reset mid-transfer clears valid
    memReady = 1'b0;
    drive(1'b0, 32'h0000_9000, 32'h11111111);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset valid", 64'(memValid), 64'(0));
    check("R1 reset ready", 64'(reqReady), 64'(1));
    finishRun();
  end
endmodule